// File: doc/BRIEF.md
# Dual-Clock FIFO with Configurable Synchronizers

This block moves data words from one clock domain to another through a small storage array. The writer and the reader each run on their own clock, and each side has its own flag and its own count of stored words. The pointers that cross between the domains are Gray coded, and each crossing passes through a chain of synchronizer flops. A parameter sets the chain depth for each direction. When the two clocks are known to be phase-related integer multiples of each other, a parameter cuts both chains to a single flop.

The write side follows stream rules. A word on `wr_data` is taken at a rising `wr_clk` edge when `wr_valid` is high and `wr_full` is low, so `wr_full` is the back-pressure signal. The producer holds its word and keeps `wr_valid` high until `wr_full` is low at a clock edge. The read side works as a request port. A rising `rd_clk` edge that sees `rd_req` high and `rd_empty` low removes the oldest word. That word appears on `rd_data` one edge later, with `rd_dvalid` high for that one cycle.

Each side computes its flag and its count from the other side's pointer, which arrives late through the synchronizer chain. So `wr_full` can stay high, and `rd_empty` can stay high, for a few cycles too long, but never too short. A single active-high clear, `aclr`, resets both sides asynchronously. Separate options make the release of the clear wait two clock edges in the write domain, the read domain, or both. Another option adds one bit to both counts so that a full FIFO reports its depth instead of zero. Guards block writes while full and reads while empty, and each guard can be turned off. `ADDR_W` must be at least 2, so the depth is at least 4.

Top module: `xclk_fifo`

## Requirements
- R1: Every word taken at the write side comes out at the read side exactly once and in the order it was written. No word is lost or repeated, whatever the ratio between the two clocks.
- R2: `wr_full` is high when the write side sees 2^ADDR_W words stored. It goes low once reads made at the read side have crossed into the write domain.
- R3: `rd_empty` is high when the read side sees no stored word, including right after a clear. It stays low while any written word that has become visible is still unread, and this includes the case where the FIFO is full.
- R4: `wr_count` is the number of words the write side sees stored, and `rd_count` is the number the read side sees. With the extra-bit option off (EXTRA_MSB=0), each count is ADDR_W bits wide, so a full FIFO reports 0.
- R5: With EXTRA_MSB=1, both counts are ADDR_W+1 bits wide and a full FIFO reports 2^ADDR_W on both of them.
- R6: With the overflow guard on (OVF_GUARD=1, the default), `wr_valid` is ignored while `wr_full` is high. The word offered is dropped, the count does not change, and the stored words are not changed.
- R7: With the underflow guard on (UNF_GUARD=1, the default), `rd_req` is ignored while `rd_empty` is high. `rd_dvalid` stays low and the read position does not move, so later words still come out correctly.
- R8: `rd_dvalid` is high, with the word on `rd_data`, in the `rd_clk` cycle right after the edge that accepted a read.
- R9: When `aclr` goes high, both sides are cleared at once, without waiting for a clock edge. The stored words are discarded, `rd_empty` goes high, `wr_full` goes low, both counts become 0 and `rd_dvalid` goes low.
- R10: With WR_CLR_SYNC=1, the write side stays cleared through the first two `wr_clk` edges after `aclr` falls and ignores writes at those two edges. With WR_CLR_SYNC=0, the first edge after `aclr` falls already takes a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| aclr | input | 1 | Asynchronous clear for both domains, active high |
| wr_valid | input | 1 | A word is offered on wr_data |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Write side sees no free slot (back-pressure) |
| wr_count | output | ADDR_W+EXTRA_MSB | Stored words as seen by the write side |
| rd_req | input | 1 | Request to remove the oldest word |
| rd_data | output | DATA_W | Word removed by the last accepted request |
| rd_dvalid | output | 1 | rd_data holds a new word this cycle |
| rd_empty | output | 1 | Read side sees no stored word |
| rd_count | output | ADDR_W+EXTRA_MSB | Stored words as seen by the read side |

## Verification
The assertions assume three things about the inputs. `wr_valid`, `wr_data` and `rd_req` change only away from their own clock edges. `aclr` is driven from the environment as a clean level. The related-clocks setting is left off when the clocks are unrelated. The bench changes every input half a period away from the edge that samples it. It places the edges of `aclr` at fractional-nanosecond offsets that no clock edge of either domain can hit. It runs the two clocks at 8 ns and 13 ns, so their phase keeps drifting and the crossings see every alignment. A second instance receives the same writes with the extra count bit on, clear synchronization on in both domains and deeper chains. This second instance lets the bench compare the count width and the clear release against the default instance.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  // Number of synchronizer flops a crossing really uses.
  function automatic int stages_used(input int related, input int asked);
    if (related != 0) return 1;
    return (asked < 1) ? 1 : asked;
  endfunction
endpackage

// File: rtl/xclk_fifo_clr_sync.sv
module xclk_fifo_clr_sync #(
  parameter int ENABLE = 0
) (
  input  logic clk,
  input  logic aclr,
  output logic clr
);
  generate
    if (ENABLE != 0) begin : g_release
      logic [1:0] hold;
      always_ff @(posedge clk or posedge aclr) begin
        if (aclr) hold <= 2'b11;
        else      hold <= {hold[0], 1'b0};
      end
      assign clr = hold[1];
    end else begin : g_direct
      assign clr = aclr;
    end
  endgenerate
endmodule

// File: rtl/xclk_fifo_sync_chain.sv
module xclk_fifo_sync_chain #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xclk_fifo_wr_ctl.sv
module xclk_fifo_wr_ctl #(
  parameter int ADDR_W    = 4,
  parameter int EXTRA_MSB = 0,
  parameter int OVF_GUARD = 1
) (
  input  logic                        clk,
  input  logic                        clr,
  input  logic                        wr_valid,
  input  logic [ADDR_W:0]             rq_gray,
  output logic                        wr_en,
  output logic [ADDR_W-1:0]           addr,
  output logic [ADDR_W:0]             gray,
  output logic                        full,
  output logic [ADDR_W+EXTRA_MSB-1:0] count
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] ptr_bin, ptr_nxt, rq_bin, diff;

  always_comb begin
    for (int i = 0; i < PW; i++) rq_bin[i] = ^(rq_gray >> i);
  end

  assign diff  = ptr_bin - rq_bin;
  assign full  = (diff == PW'(DEPTH));
  assign wr_en = wr_valid & (~full | (OVF_GUARD == 0));
  assign ptr_nxt = ptr_bin + PW'(1);
  assign addr  = ptr_bin[ADDR_W-1:0];

  generate
    if (EXTRA_MSB != 0) begin : g_wide
      assign count = diff;
    end else begin : g_narrow
      assign count = diff[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      ptr_bin <= '0;
      gray    <= '0;
    end else if (wr_en) begin
      ptr_bin <= ptr_nxt;
      gray    <= ptr_nxt ^ (ptr_nxt >> 1);
    end
  end
endmodule

// File: rtl/xclk_fifo_rd_ctl.sv
module xclk_fifo_rd_ctl #(
  parameter int ADDR_W    = 4,
  parameter int EXTRA_MSB = 0,
  parameter int UNF_GUARD = 1
) (
  input  logic                        clk,
  input  logic                        clr,
  input  logic                        rd_req,
  input  logic [ADDR_W:0]             wq_gray,
  output logic                        rd_en,
  output logic [ADDR_W-1:0]           addr,
  output logic [ADDR_W:0]             gray,
  output logic                        empty,
  output logic [ADDR_W+EXTRA_MSB-1:0] count,
  output logic                        dvalid
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] ptr_bin, ptr_nxt, wq_bin, diff;

  always_comb begin
    for (int i = 0; i < PW; i++) wq_bin[i] = ^(wq_gray >> i);
  end

  assign diff    = wq_bin - ptr_bin;
  assign empty   = (diff == '0);
  assign rd_en   = rd_req & (~empty | (UNF_GUARD == 0));
  assign ptr_nxt = ptr_bin + PW'(1);
  assign addr    = ptr_bin[ADDR_W-1:0];

  generate
    if (EXTRA_MSB != 0) begin : g_wide
      assign count = diff;
    end else begin : g_narrow
      assign count = diff[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      ptr_bin <= '0;
      gray    <= '0;
      dvalid  <= 1'b0;
    end else begin
      dvalid <= rd_en;
      if (rd_en) begin
        ptr_bin <= ptr_nxt;
        gray    <= ptr_nxt ^ (ptr_nxt >> 1);
      end
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 4,
  parameter int W2R_STAGES   = 2,
  parameter int R2W_STAGES   = 2,
  parameter int RELATED_CLKS = 0,
  parameter int EXTRA_MSB    = 0,
  parameter int WR_CLR_SYNC  = 0,
  parameter int RD_CLR_SYNC  = 0,
  parameter int OVF_GUARD    = 1,
  parameter int UNF_GUARD    = 1
) (
  input  logic                        wr_clk,
  input  logic                        rd_clk,
  input  logic                        aclr,
  input  logic                        wr_valid,
  input  logic [DATA_W-1:0]           wr_data,
  output logic                        wr_full,
  output logic [ADDR_W+EXTRA_MSB-1:0] wr_count,
  input  logic                        rd_req,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_dvalid,
  output logic                        rd_empty,
  output logic [ADDR_W+EXTRA_MSB-1:0] rd_count
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  localparam int W2R_N = stages_used(RELATED_CLKS, W2R_STAGES);
  localparam int R2W_N = stages_used(RELATED_CLKS, R2W_STAGES);

  logic              wr_clr, rd_clr;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wr_gray, rd_gray, wq_gray, rq_gray;
  logic [DATA_W-1:0] mem [DEPTH];

  xclk_fifo_clr_sync #(.ENABLE(WR_CLR_SYNC)) u_wclr (
    .clk(wr_clk), .aclr(aclr), .clr(wr_clr)
  );
  xclk_fifo_clr_sync #(.ENABLE(RD_CLR_SYNC)) u_rclr (
    .clk(rd_clk), .aclr(aclr), .clr(rd_clr)
  );

  xclk_fifo_wr_ctl #(
    .ADDR_W(ADDR_W), .EXTRA_MSB(EXTRA_MSB), .OVF_GUARD(OVF_GUARD)
  ) u_wctl (
    .clk(wr_clk), .clr(wr_clr), .wr_valid(wr_valid), .rq_gray(rq_gray),
    .wr_en(wr_en), .addr(waddr), .gray(wr_gray), .full(wr_full),
    .count(wr_count)
  );

  xclk_fifo_rd_ctl #(
    .ADDR_W(ADDR_W), .EXTRA_MSB(EXTRA_MSB), .UNF_GUARD(UNF_GUARD)
  ) u_rctl (
    .clk(rd_clk), .clr(rd_clr), .rd_req(rd_req), .wq_gray(wq_gray),
    .rd_en(rd_en), .addr(raddr), .gray(rd_gray), .empty(rd_empty),
    .count(rd_count), .dvalid(rd_dvalid)
  );

  // write pointer into the read domain
  xclk_fifo_sync_chain #(.W(PW), .STAGES(W2R_N)) u_w2r (
    .clk(rd_clk), .clr(rd_clr), .d(wr_gray), .q(wq_gray)
  );
  // read pointer into the write domain
  xclk_fifo_sync_chain #(.W(PW), .STAGES(R2W_N)) u_r2w (
    .clk(wr_clk), .clr(wr_clr), .d(rd_gray), .q(rq_gray)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk or posedge rd_clr) begin
    if (rd_clr)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[raddr];
  end
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int ADDR_W    = 4,
  parameter int EXTRA_MSB = 0,
  parameter int OVF_GUARD = 1,
  parameter int UNF_GUARD = 1
) (
  input logic                        wr_clk,
  input logic                        rd_clk,
  input logic                        wr_clr,
  input logic                        rd_clr,
  input logic                        wr_full,
  input logic [ADDR_W+EXTRA_MSB-1:0] wr_count,
  input logic [ADDR_W:0]             wr_gray,
  input logic [ADDR_W:0]             rd_gray,
  input logic                        rd_empty,
  input logic [ADDR_W+EXTRA_MSB-1:0] rd_count,
  input logic                        rd_dvalid
);
  localparam int CNT_W = ADDR_W + EXTRA_MSB;
  localparam logic [CNT_W-1:0] FULL_CNT =
    (EXTRA_MSB != 0) ? CNT_W'(1 << ADDR_W) : '0;

  // R6: a full write side must not move its pointer
  a_r6_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_clr)
    (OVF_GUARD != 0 && wr_full) |=> $stable(wr_gray));

  // R7: an empty read side must produce no data
  a_r7_no_underflow: assert property (@(posedge rd_clk) disable iff (rd_clr)
    (UNF_GUARD != 0 && rd_empty) |=> !rd_dvalid);

  // R4 and R5: count reported while full
  a_r4_full_count: assert property (@(posedge wr_clk) disable iff (wr_clr)
    wr_full |-> (wr_count == FULL_CNT));

  // R3: empty reads as a zero count
  a_r3_empty_count: assert property (@(posedge rd_clk) disable iff (rd_clr)
    rd_empty |-> (rd_count == '0));

  // R1: crossing pointers step one Gray bit at a time
  a_r1_wr_gray_step: assert property (@(posedge wr_clk) disable iff (wr_clr)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
  a_r1_rd_gray_step: assert property (@(posedge rd_clk) disable iff (rd_clr)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind xclk_fifo xclk_fifo_chk #(
  .ADDR_W(ADDR_W), .EXTRA_MSB(EXTRA_MSB),
  .OVF_GUARD(OVF_GUARD), .UNF_GUARD(UNF_GUARD)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_clr(wr_clr), .rd_clr(rd_clr),
  .wr_full(wr_full), .wr_count(wr_count), .wr_gray(wr_gray),
  .rd_gray(rd_gray), .rd_empty(rd_empty), .rd_count(rd_count),
  .rd_dvalid(rd_dvalid)
);

// File: tb/xclk_fifo_tb.sv
`timescale 1ns/100ps
module xclk_fifo_tb;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic aclr = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = '0;

  logic       wr_full, rd_dvalid, rd_empty;
  logic [3:0] wr_count, rd_count;
  logic [7:0] rd_data;

  logic       x_full, x_dvalid, x_empty;
  logic [4:0] x_wcount, x_rcount;
  logic [7:0] x_data;

  always #4   wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  xclk_fifo u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .aclr(aclr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(wr_full),
    .wr_count(wr_count), .rd_req(rd_req), .rd_data(rd_data),
    .rd_dvalid(rd_dvalid), .rd_empty(rd_empty), .rd_count(rd_count)
  );

  xclk_fifo #(
    .W2R_STAGES(3), .R2W_STAGES(3), .EXTRA_MSB(1),
    .WR_CLR_SYNC(1), .RD_CLR_SYNC(1)
  ) u_dut_x (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .aclr(aclr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(x_full),
    .wr_count(x_wcount), .rd_req(1'b0), .rd_data(x_data),
    .rd_dvalid(x_dvalid), .rd_empty(x_empty), .rd_count(x_rcount)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  int rd_mode = 0;   // 0 idle, 1 always, 2 pattern, 3 manual
  logic [7:0] exp_q[$];
  logic [7:0] exp_w;
  logic [7:0] lf = 8'hA5;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_word(input logic [7:0] d);
    @(negedge wr_clk);
    while (wr_full) @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data  = d;
    exp_q.push_back(d);
    @(posedge wr_clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge rd_clk);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge rd_clk);
    settle();
  endtask

  // reader
  initial begin
    forever begin
      @(negedge rd_clk);
      if (rd_mode == 0) rd_req = 1'b0;
      else if (rd_mode == 1) rd_req = 1'b1;
      else if (rd_mode == 2) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        rd_req = lf[0] | lf[3];
      end
    end
  end

  // monitor / scoreboard
  always @(negedge rd_clk) begin
    if (!aclr && rd_dvalid) begin
      if (exp_q.size() == 0)
        check(1'b0, "R1 word with none expected", int'(rd_data), -1);
      else begin
        exp_w = exp_q.pop_front();
        check(rd_data == exp_w, "R1 order", int'(rd_data), int'(exp_w));
      end
    end
  end

  initial begin
    #1_400_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1 aclr = 1'b1;
    #29.3 aclr = 1'b0;
    settle();
    // reset state
    check(rd_empty == 1'b1, "R3 empty after reset", rd_empty, 1);
    check(wr_full == 1'b0, "R2 not full after reset", wr_full, 0);
    check(wr_count == 0, "R4 wr_count after reset", wr_count, 0);
    check(rd_count == 0, "R4 rd_count after reset", rd_count, 0);
    check(rd_dvalid == 1'b0, "R8 no data after reset", rd_dvalid, 0);

    // partial fill
    for (int i = 0; i < 5; i++) push_word(8'(8'h10 + i));
    settle();
    check(wr_count == 5, "R4 wr_count five", wr_count, 5);
    check(rd_count == 5, "R4 rd_count five", rd_count, 5);
    check(rd_empty == 1'b0, "R3 not empty with data", rd_empty, 0);
    check(x_wcount == 5, "R5 wide count five", x_wcount, 5);

    // streaming with irregular reads
    rd_mode = 2;
    for (int i = 0; i < 300; i++) push_word(8'(i) ^ 8'h5A);
    wait_drain();
    check(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 0);
    check(rd_empty == 1'b1, "R3 empty after drain", rd_empty, 1);

    // fill to the top
    rd_mode = 0;
    settle();
    for (int i = 0; i < 16; i++) push_word(8'(8'hA0 + i));
    settle();
    check(wr_full == 1'b1, "R2 full at depth", wr_full, 1);
    check(wr_count == 0, "R4 wr_count wraps at full", wr_count, 0);
    check(rd_count == 0, "R4 rd_count wraps at full", rd_count, 0);
    check(rd_empty == 1'b0, "R3 not empty when full", rd_empty, 0);
    check(x_full == 1'b1, "R5 wide instance full", x_full, 1);
    check(x_wcount == 16, "R5 wide wr_count depth", x_wcount, 16);
    check(x_rcount == 16, "R5 wide rd_count depth", x_rcount, 16);

    // writes while full are dropped
    for (int i = 0; i < 4; i++) begin
      @(negedge wr_clk);
      wr_valid = 1'b1;
      wr_data  = 8'hEE;
      @(posedge wr_clk);
      #1 wr_valid = 1'b0;
    end
    settle();
    check(wr_full == 1'b1, "R6 still full", wr_full, 1);
    check(wr_count == 0, "R6 count unchanged", wr_count, 0);

    // directed drain with latency check
    rd_mode = 3;
    for (int i = 0; i < 16; i++) begin
      @(negedge rd_clk);
      rd_req = 1'b1;
      @(posedge rd_clk);
      #1 rd_req = 1'b0;
      @(negedge rd_clk);
      check(rd_dvalid == 1'b1, "R8 data one edge after request", rd_dvalid, 1);
    end
    settle();
    check(exp_q.size() == 0, "R6 only original words read", exp_q.size(), 0);
    check(rd_empty == 1'b1, "R3 empty after directed drain", rd_empty, 1);
    check(wr_full == 1'b0, "R2 full released", wr_full, 0);

    // reads while empty
    @(negedge rd_clk);
    rd_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge rd_clk);
      check(rd_dvalid == 1'b0, "R7 no data from empty", rd_dvalid, 0);
    end
    rd_req = 1'b0;
    for (int i = 0; i < 3; i++) push_word(8'(8'h70 + i));
    rd_mode = 1;
    wait_drain();
    check(exp_q.size() == 0, "R7 pointer intact after empty reads", exp_q.size(), 0);

    // asynchronous clear
    rd_mode = 0;
    for (int i = 0; i < 4; i++) push_word(8'(8'hC0 + i));
    settle();
    @(negedge wr_clk);
    #0.3 aclr = 1'b1;
    #0.3;
    check(rd_empty == 1'b1, "R9 empty on clear", rd_empty, 1);
    check(rd_count == 0, "R9 rd_count on clear", rd_count, 0);
    check(wr_count == 0, "R9 wr_count on clear", wr_count, 0);
    check(x_full == 1'b0, "R9 full dropped on clear", x_full, 0);
    exp_q.delete();
    #20;

    // clear release timing
    @(negedge wr_clk);
    #0.3 aclr = 1'b0;
    wr_valid = 1'b1;
    wr_data  = 8'h3C;
    for (int i = 0; i < 3; i++) exp_q.push_back(8'h3C);
    repeat (3) @(posedge wr_clk);
    #1 wr_valid = 1'b0;
    settle();
    check(wr_count == 3, "R10 direct release takes first edge", wr_count, 3);
    check(x_wcount == 1, "R10 synced release skips two edges", x_wcount, 1);
    rd_mode = 2;
    wait_drain();
    check(exp_q.size() == 0, "R9 only post-clear words read", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule